// File: doc/BRIEF.md
# Mode-Aware Partial-Width Register File

This block holds sixteen 64-bit general-purpose registers. It has one write port and two combinational read ports. Three control inputs select the execution mode: a long-mode-active bit, a code-segment long bit and a code-segment default-size bit. A mode decoder turns them into an execution mode and default operand and address sizes. Three prefix-style override inputs then adjust those sizes.

Each write carries its own size code. The write-merge stage either replaces the whole register, zero-extends a 32-bit result, or merges an 8-bit or 16-bit result into the low bits. The mode decides which register indices can be reached and whether a 64-bit write is allowed. A write that is not allowed is dropped and raises a one-cycle illegal-access pulse. In compatibility mode each read port also reports when its value could not be used as an address below 4 GB.

The design has no sequential control state. Its only named "states" are the four decoded execution modes: legacy, compatibility, 64-bit and reserved. The mode changes whenever the three mode inputs change, with no intermediate transition.

Top module: `gpr_mode_regfile`

## Requirements
- R1: Encodings are mode 0=legacy, 1=compatibility, 2=64-bit, 3=reserved, and size 0=8, 1=16, 2=32, 3=64 bits. With the long-mode-active bit at 0 the mode is legacy, the long bit is ignored, and both default sizes are 16 when the default-size bit is 0 and 32 when it is 1.
- R2: With long-mode-active at 1 and long bit at 0 the mode is compatibility, with the same default-size selection as legacy mode.
- R3: With long-mode-active 1, long bit 1 and default-size bit 0 the mode is 64-bit, with operand size 32 and address size 64 when no override is present.
- R4: Long-mode-active 1, long bit 1, default-size bit 1 gives mode 3 with mode_err high and sizes 32/64. Every write in this mode is suppressed and raises illegal.
- R5: In 64-bit mode ovr_op64 forces operand size 64 and takes priority over ovr_op16, which forces 16; ovr_addr forces address size 32. In legacy and compatibility modes ovr_op16 swaps the operand size between 16 and 32, ovr_addr swaps the address size between 16 and 32, and ovr_op64 has no effect.
- R6: A legal 32-bit write stores the low 32 data bits with bits 63:32 cleared.
- R7: A legal 8-bit or 16-bit write replaces only bits 7:0 or 15:0 respectively; all higher bits keep their old values.
- R8: In 64-bit mode a 64-bit write replaces all bits. Indices 8 to 15 are writable, at any size including a byte into bits 7:0, only when ext_pfx is 1; without it such a write is suppressed and raises illegal.
- R9: Outside 64-bit mode a write to index 8 to 15, or a write of size 64, is suppressed. illegal is high for exactly the one cycle after that write's clock edge.
- R10: Reads are combinational and a read of the register being written in the same cycle returns the old value. Outside 64-bit mode a read of index 8 to 15 returns zero.
- R11: Reset clears every register to zero and clears illegal.
- R12: rd_a_aerr and rd_b_aerr are high exactly when the mode is compatibility and bits 63:32 of that port's read data are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lma | input | 1 | Long-mode-active control bit |
| cs_l | input | 1 | Code-segment long bit |
| cs_d | input | 1 | Code-segment default-size bit |
| ovr_op64 | input | 1 | Operand-size-64 override |
| ovr_op16 | input | 1 | Operand-size override (16 in 64-bit mode, swap otherwise) |
| ovr_addr | input | 1 | Address-size override |
| ext_pfx | input | 1 | Register-extension prefix present |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 64 | Write data |
| rd_a_idx | input | 4 | Read port A index |
| rd_b_idx | input | 4 | Read port B index |
| rd_a_data | output | 64 | Read port A data |
| rd_b_data | output | 64 | Read port B data |
| rd_a_aerr | output | 1 | Port A address-range error |
| rd_b_aerr | output | 1 | Port B address-range error |
| mode | output | 2 | Decoded execution mode |
| eff_opsz | output | 2 | Effective operand size code |
| eff_adsz | output | 2 | Effective address size code |
| mode_err | output | 1 | Reserved mode combination flag |
| illegal | output | 1 | Suppressed-write pulse |

## Verification
The assertions check the following on every cycle. A suppressed write always raises illegal, and illegal never appears without a write on the cycle before. A 32-bit write reads back zero-extended on the next cycle, and a byte write leaves bits 63:8 intact. The address-range flag matches the mode and the upper half of the read data, and the 64-bit mode defaults appear when no override is set. Other behaviour can only be shown by the bench's scenarios: that a suppressed write really leaves the stored value untouched, which can be seen by switching modes and reading back; the full decode table with every override pattern; same-cycle read of the old value; and reaching indices 8 to 15 with and without the extension prefix.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_COMPAT = 2'd1,
        MODE_LONG   = 2'd2,
        MODE_RSVD   = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } size_e;

    function automatic size_e swap_16_32(input size_e s);
        return (s == SZ16) ? SZ32 : SZ16;
    endfunction
endpackage

// File: rtl/gpr_mode_decode.sv
module gpr_mode_decode
    import gpr_pkg::*;
(
    input  logic      lma,
    input  logic      cs_l,
    input  logic      cs_d,
    input  logic      ovr_op64,
    input  logic      ovr_op16,
    input  logic      ovr_addr,
    output cpu_mode_e mode,
    output size_e     op_sz,
    output size_e     ad_sz,
    output logic      rsvd
);
    size_e def_sz;

    always_comb begin
        mode   = MODE_LEGACY;
        def_sz = SZ16;
        unique case ({lma, cs_l, cs_d})
            3'b000, 3'b010: begin mode = MODE_LEGACY; def_sz = SZ16; end
            3'b001, 3'b011: begin mode = MODE_LEGACY; def_sz = SZ32; end
            3'b100:         begin mode = MODE_COMPAT; def_sz = SZ16; end
            3'b101:         begin mode = MODE_COMPAT; def_sz = SZ32; end
            3'b110:         begin mode = MODE_LONG;   def_sz = SZ32; end
            3'b111:         begin mode = MODE_RSVD;   def_sz = SZ32; end
            default:        begin mode = MODE_LEGACY; def_sz = SZ16; end
        endcase
    end

    always_comb begin
        rsvd = 1'b0;
        unique case (mode)
            MODE_LONG: begin
                op_sz = ovr_op64 ? SZ64 : (ovr_op16 ? SZ16 : SZ32);
                ad_sz = ovr_addr ? SZ32 : SZ64;
            end
            MODE_RSVD: begin
                op_sz = SZ32;
                ad_sz = SZ64;
                rsvd  = 1'b1;
            end
            default: begin
                op_sz = ovr_op16 ? swap_16_32(def_sz) : def_sz;
                ad_sz = ovr_addr ? swap_16_32(def_sz) : def_sz;
            end
        endcase
    end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
    import gpr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] new_val,
    input  size_e           size,
    output logic [XLEN-1:0] merged
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        unique case (size)
            SZ8:  merged = {old_val[XLEN-1:8],  new_val[7:0]};
            SZ16: merged = {old_val[XLEN-1:16], new_val[15:0]};
            SZ32: merged = {{HALF{1'b0}}, new_val[HALF-1:0]};
            SZ64: merged = new_val;
            default: merged = old_val;
        endcase
    end
endmodule

// File: rtl/gpr_reg_array.sv
module gpr_reg_array #(
    parameter int NREG = 16,
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_val,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [IDX_W-1:0] b_idx,
    output logic [XLEN-1:0]  a_data,
    output logic [XLEN-1:0]  b_data,
    output logic [XLEN-1:0]  old_data
);
    logic [XLEN-1:0] regs [NREG];
    logic [NREG-1:0] we;

    for (genvar g = 0; g < NREG; g++) begin : g_we
        assign we[g] = wr_ok && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)     regs[i] <= '0;
            else if (we[i]) regs[i] <= wr_val;
        end
    end

    assign a_data   = regs[a_idx];
    assign b_data   = regs[b_idx];
    assign old_data = regs[wr_idx];
endmodule

// File: rtl/gpr_mode_regfile.sv
module gpr_mode_regfile
    import gpr_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int NREG_LEG = 8,
    parameter int XLEN     = 64,
    localparam int IDX_W   = $clog2(NREG),
    localparam int HALF    = XLEN / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lma,
    input  logic             cs_l,
    input  logic             cs_d,
    input  logic             ovr_op64,
    input  logic             ovr_op16,
    input  logic             ovr_addr,
    input  logic             ext_pfx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]  rd_a_data,
    output logic [XLEN-1:0]  rd_b_data,
    output logic             rd_a_aerr,
    output logic             rd_b_aerr,
    output logic [1:0]       mode,
    output logic [1:0]       eff_opsz,
    output logic [1:0]       eff_adsz,
    output logic             mode_err,
    output logic             illegal
);
    localparam logic [IDX_W-1:0] LEG_LIM = IDX_W'(NREG_LEG);

    cpu_mode_e       cur_mode;
    size_e           op_sz, ad_sz;
    logic            rsvd;
    logic            wr_ok, reach_ok, size_ok;
    logic            illegal_q;
    logic [XLEN-1:0] a_raw, b_raw, old_val, merged;

    gpr_mode_decode u_dec (
        .lma(lma), .cs_l(cs_l), .cs_d(cs_d),
        .ovr_op64(ovr_op64), .ovr_op16(ovr_op16), .ovr_addr(ovr_addr),
        .mode(cur_mode), .op_sz(op_sz), .ad_sz(ad_sz), .rsvd(rsvd)
    );

    always_comb begin
        unique case (cur_mode)
            MODE_LONG: begin
                reach_ok = (wr_idx < LEG_LIM) || ext_pfx;
                size_ok  = 1'b1;
            end
            MODE_RSVD: begin
                reach_ok = 1'b0;
                size_ok  = 1'b0;
            end
            default: begin
                reach_ok = (wr_idx < LEG_LIM);
                size_ok  = (size_e'(wr_size) != SZ64);
            end
        endcase
        wr_ok = wr_en && reach_ok && size_ok;
    end

    gpr_write_merge #(.XLEN(XLEN)) u_merge (
        .old_val(old_val), .new_val(wr_data),
        .size(size_e'(wr_size)), .merged(merged)
    );

    gpr_reg_array #(.NREG(NREG), .XLEN(XLEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_idx(wr_idx),
        .wr_val(merged), .a_idx(rd_a_idx), .b_idx(rd_b_idx),
        .a_data(a_raw), .b_data(b_raw), .old_data(old_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= wr_en && !wr_ok;
    end

    always_comb begin
        rd_a_data = a_raw;
        rd_b_data = b_raw;
        if (cur_mode != MODE_LONG) begin
            if (rd_a_idx >= LEG_LIM) rd_a_data = '0;
            if (rd_b_idx >= LEG_LIM) rd_b_data = '0;
        end
        rd_a_aerr = (cur_mode == MODE_COMPAT) && (|rd_a_data[XLEN-1:HALF]);
        rd_b_aerr = (cur_mode == MODE_COMPAT) && (|rd_b_data[XLEN-1:HALF]);
    end

    assign mode     = cur_mode;
    assign eff_opsz = op_sz;
    assign eff_adsz = ad_sz;
    assign mode_err = rsvd;
    assign illegal  = illegal_q;
endmodule

// File: rtl/gpr_mode_regfile_chk.sv
module gpr_mode_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ovr_op64,
    input logic        ovr_op16,
    input logic        ovr_addr,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [1:0]  wr_size,
    input logic [63:0] wr_data,
    input logic [3:0]  rd_a_idx,
    input logic [63:0] rd_a_data,
    input logic        rd_a_aerr,
    input logic [1:0]  mode,
    input logic [1:0]  eff_opsz,
    input logic [1:0]  eff_adsz,
    input logic        mode_err,
    input logic        illegal
);
    p_def_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !ovr_op64 && !ovr_op16 && !ovr_addr)
        |-> (eff_opsz == 2'd2 && eff_adsz == 2'd3));

    p_rsvd_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_err) |=> illegal);

    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && wr_size == 2'd2 && wr_idx < 4'd8 && !mode_err)
         && rd_a_idx == $past(wr_idx))
        |-> rd_a_data == {32'h0, $past(wr_data[31:0])});

    p_byte_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && wr_size == 2'd0 && wr_idx < 4'd8 && !mode_err && rd_a_idx == wr_idx)
         && rd_a_idx == $past(rd_a_idx))
        |-> (rd_a_data[63:8] == $past(rd_a_data[63:8])
             && rd_a_data[7:0] == $past(wr_data[7:0])));

    p_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode != 2'd2 && (wr_idx >= 4'd8 || wr_size == 2'd3)) |=> illegal);

    p_pulse_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> !illegal);

    p_aerr_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_aerr |-> (mode == 2'd1 && rd_a_data[63:32] != 32'h0));

    p_aerr_raise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && rd_a_data[63:32] != 32'h0) |-> rd_a_aerr);
endmodule

bind gpr_mode_regfile gpr_mode_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ovr_op64(ovr_op64), .ovr_op16(ovr_op16),
    .ovr_addr(ovr_addr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_a_aerr(rd_a_aerr), .mode(mode), .eff_opsz(eff_opsz),
    .eff_adsz(eff_adsz), .mode_err(mode_err), .illegal(illegal)
);

// File: tb/gpr_mode_regfile_bench.sv
module gpr_mode_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lma = 0, cs_l = 0, cs_d = 0;
    logic        ovr_op64 = 0, ovr_op16 = 0, ovr_addr = 0, ext_pfx = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [1:0]  wr_size = 0;
    logic [63:0] wr_data = 0;
    logic [3:0]  rd_a_idx = 0, rd_b_idx = 0;
    logic [63:0] rd_a_data, rd_b_data;
    logic        rd_a_aerr, rd_b_aerr, mode_err, illegal;
    logic [1:0]  mode, eff_opsz, eff_adsz;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gpr_mode_regfile u_gpr_mode_regfile (.*);

    // {lma,l,d,ovr64,ovr16,ovr_addr, mode, opsz, adsz, err}
    localparam logic [12:0] VEC [13] = '{
        13'b000_000_00_01_01_0,  // R1 legacy 16
        13'b011_000_00_10_10_0,  // R1 legacy 32, L ignored
        13'b001_010_00_01_10_0,  // R5 op swap in legacy
        13'b010_001_00_01_10_0,  // R5 addr swap in legacy
        13'b001_100_00_10_10_0,  // R5 op64 ignored in legacy
        13'b100_000_01_01_01_0,  // R2 compat 16
        13'b101_011_01_01_01_0,  // R2 compat 32 with both swaps
        13'b110_000_10_10_11_0,  // R3 64-bit defaults
        13'b110_100_10_11_11_0,  // R5 op64
        13'b110_010_10_01_11_0,  // R5 op16
        13'b110_110_10_11_11_0,  // R5 op64 priority
        13'b110_001_10_10_10_0,  // R5 addr32
        13'b111_000_11_10_11_1   // R4 reserved
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic a, input logic l, input logic d);
        lma = a; cs_l = l; cs_d = d;
    endtask

    // drive at negedge, edge commits, returns at next negedge
    task automatic wr(input logic [3:0] idx, input logic [1:0] sz, input logic [63:0] d);
        wr_en = 1; wr_idx = idx; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        #1;
    endtask

    task automatic rd(input logic [3:0] idx);
        rd_a_idx = idx; rd_b_idx = idx;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rd(4'd0);
        chk("R11 reset reg0", rd_a_data, 64'h0);
        chk("R11 reset illegal", {63'h0, illegal}, 64'h0);
        rst_n = 1;
        @(negedge clk);

        // decode table
        for (int i = 0; i < 13; i++) begin
            {lma, cs_l, cs_d, ovr_op64, ovr_op16, ovr_addr} = VEC[i][12:7];
            #1;
            chk($sformatf("R1-5 vector %0d", i),
                {57'h0, mode, eff_opsz, eff_adsz, mode_err}, {57'h0, VEC[i][6:0]});
        end
        {ovr_op64, ovr_op16, ovr_addr} = 3'b000;

        // 64-bit mode writes
        set_mode(1, 1, 0);
        wr(4'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF); rd(4'd3);
        chk("R8 full write", rd_a_data, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(4'd3, 2'd2, 64'hAAAA_BBBB_1234_5678); rd(4'd3);
        chk("R6 zero extend", rd_a_data, 64'h0000_0000_1234_5678);
        wr(4'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(4'd3, 2'd1, 64'h1111_2222_3333_ABCD); rd(4'd3);
        chk("R7 word merge", rd_a_data, 64'hFFFF_FFFF_FFFF_ABCD);
        wr(4'd3, 2'd0, 64'h1111_2222_3333_445A); rd(4'd3);
        chk("R7 byte merge", rd_b_data, 64'hFFFF_FFFF_FFFF_AB5A);

        // same-cycle read returns old value
        rd_a_idx = 4'd3;
        wr_en = 1; wr_idx = 4'd3; wr_size = 2'd3; wr_data = 64'h0123_4567_89AB_CDEF;
        #1;
        chk("R10 old value", rd_a_data, 64'hFFFF_FFFF_FFFF_AB5A);
        @(negedge clk); wr_en = 0; #1;
        chk("R10 new value after edge", rd_a_data, 64'h0123_4567_89AB_CDEF);

        // extended index
        ext_pfx = 1;
        wr(4'd12, 2'd3, 64'h1111_2222_3333_4444);
        wr(4'd12, 2'd0, 64'h0000_0000_0000_0099); rd(4'd12);
        chk("R8 ext byte r12", rd_a_data, 64'h1111_2222_3333_4499);
        ext_pfx = 0;
        wr(4'd12, 2'd3, 64'h0);
        chk("R8 no-prefix illegal", {63'h0, illegal}, 64'h1);
        rd(4'd12);
        chk("R8 no-prefix unchanged", rd_a_data, 64'h1111_2222_3333_4499);

        // compatibility mode
        set_mode(1, 0, 1);
        wr(4'd12, 2'd2, 64'h5);
        chk("R9 high index illegal", {63'h0, illegal}, 64'h1);
        @(negedge clk); #1;
        chk("R9 pulse one cycle", {63'h0, illegal}, 64'h0);
        rd(4'd12);
        chk("R10 high index reads zero", rd_a_data, 64'h0);
        wr(4'd2, 2'd3, 64'hDEAD_BEEF_DEAD_BEEF);
        chk("R9 size64 illegal", {63'h0, illegal}, 64'h1);
        rd(4'd2);
        chk("R9 size64 unchanged", rd_a_data, 64'h0);
        rd(4'd3);
        chk("R12 aerr set", {63'h0, rd_a_aerr}, 64'h1);
        wr(4'd5, 2'd2, 64'hFFFF_0000_8000_0000); rd(4'd5);
        chk("R12 aerr clear", {62'h0, rd_a_aerr, rd_b_aerr}, 64'h0);
        chk("R6 compat zero extend", rd_a_data, 64'h0000_0000_8000_0000);

        // back to 64-bit: r12 kept, no aerr
        set_mode(1, 1, 0); rd(4'd12);
        chk("R9 r12 unchanged", rd_a_data, 64'h1111_2222_3333_4499);
        rd(4'd3);
        chk("R12 no aerr in 64-bit", {63'h0, rd_a_aerr}, 64'h0);

        // legacy: byte write to low index legal
        set_mode(0, 1, 1);
        wr(4'd5, 2'd0, 64'h77);
        chk("R7 legacy byte legal", {63'h0, illegal}, 64'h0);
        rd(4'd5);
        chk("R7 legacy byte value", rd_a_data, 64'h0000_0000_8000_0077);

        // reserved mode
        set_mode(1, 1, 1);
        wr(4'd5, 2'd2, 64'h1);
        chk("R4 reserved illegal", {63'h0, illegal}, 64'h1);
        set_mode(1, 1, 0); rd(4'd5);
        chk("R4 reserved unchanged", rd_a_data, 64'h0000_0000_8000_0077);

        // reset clears again
        rst_n = 0; @(negedge clk); rst_n = 1; rd(4'd3);
        chk("R11 reset clears", rd_a_data, 64'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule